// File: doc/BRIEF.md
# Windowed Digital Watchdog Timer

This block is a down-counting watchdog that advances on a low-frequency tick enable (nominally 32,768 Hz, so the remaining time in seconds is the count divided by 32,768). Once started, software must keep it alive by writing a two-word key pair. The pair is only accepted while the service window is open. The window is a selectable trailing fraction of the programmed timeout.

Three kinds of fault are recorded in a sticky status word:
- a service attempt made before the window opens;
- a wrong key value or a key written out of order;
- reaching zero without a valid service.

Any fault also sets a summary flag. That flag drives one violation action line, which a control bit routes either to a system reset request or to a non-maskable interrupt. A second control bit turns the action into a one-cycle pulse per fault instead of a level.

Software reaches the block through a small word-addressed register port. Writes are single-cycle strobes. Reads are combinational on a separate read address.

Top module: `windowed_watchdog`

## Requirements
- R1: After reset the count is 0, the timer is stopped, the status word is 0, and both action outputs are low.
- R2: Control register (address 0): bit 0 = start, bit 1 = action select, bit 2 = pulse mode. A read returns bit 0 = running, bit 1 = select, bit 2 = pulse mode. The timeout is written at address 1, and the current count is read at address 5.
  - Writing start=1 while stopped loads the count from the timeout and sets running.
  - While running, the count falls by exactly one per cycle with the tick input high, and holds on cycles without a tick.
- R3: Window code register (address 2): the window is open when count ≤ timeout >> code. Codes 0 to 5 select 100%, 50%, 25%, 12.5%, 6.25% and 3.125% of the timeout. Codes 6 and 7 behave as code 5.
- R4: Key register (address 3); a read returns bit 0 = first key armed, bit 1 = keys locked. Writing 0xE51A and then 0xA35C while the window is open reloads the count to the timeout and leaves the status unchanged. A service in the same cycle as a tick takes priority over the tick.
- R5: Status bit 3 sets on any key write other than 0xE51A made while the window is closed. A correct pair written early therefore reads 0x28, since bit 5 also sets.
- R6: Status bit 2 sets on a key value other than the two valid keys, and on 0xA35C without a preceding 0xE51A. For example:
  - a bad first key written early reads 0x2C;
  - an unarmed 0xA35C inside the window reads 0x24.
- R7: Repeating 0xE51A only re-arms the first step and records nothing.
- R8: When a tick arrives at count 1 or 0, status bits 1, 4 and 5 set, the count stays at 0, and running clears. With no service this reads 0x32; after an early service it reads 0x3A.
- R9: After an early or bad-key fault, all key writes are ignored until the next start, while the countdown continues to zero.
- R10: Status (address 4) bits stay set until cleared by writing 1 to them. A new event in the same cycle as a clear keeps its bit set.
- R11: While running, a control write can neither stop the timer nor reload it.
- R12: The action output follows status bit 5 in level mode, and is high for exactly one cycle per fault event in pulse mode. Select 0 drives the reset request output, and select 1 drives the interrupt output. The two outputs are never both high.
- R13: A high cycle on the analog-threshold input sets status bit 0, which does not affect the action outputs.
- R14: Key writes made while the timer is stopped have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Countdown enable, one cycle per low-frequency period |
| aux_evt_i | input | 1 | Analog threshold event placeholder |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | DATA_W | Register read data (combinational) |
| rst_req_o | output | 1 | Violation action as system reset request |
| nmi_o | output | 1 | Violation action as non-maskable interrupt |

## Verification
A wrong count or window comparison shows at the count register in the cycle after the tick or key write that used it. It also changes the status word, one cycle after the key write that was judged against the window. A wrong armed or locked state shows directly in the key register read-back, and in the status word on the next key write. An action-routing or pulse-length fault shows on the two action outputs in the first cycle after the fault event. A per-cycle behavioural reference therefore exposes any of these within one clock.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // register map (3-bit word address)
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_LOAD = 3'd1;
  localparam logic [2:0] A_WIN  = 3'd2;
  localparam logic [2:0] A_KEY  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;
  localparam logic [2:0] A_CNT  = 3'd5;

  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_ARM  = 16'hE51A;
  localparam logic [KEY_W-1:0] KEY_FIRE = 16'hA35C;

  // status bit positions (decoded by software, kept fixed)
  localparam int ST_AUX   = 0;
  localparam int ST_EXP   = 1;
  localparam int ST_BAD   = 2;
  localparam int ST_EARLY = 3;
  localparam int ST_LATE  = 4;
  localparam int ST_ANY   = 5;
  localparam int ST_W     = 6;

  typedef struct packed {
    logic expire;
    logic early;
    logic badkey;
  } wdg_evt_t;

  // window code to right-shift amount; codes above 5 saturate
  function automatic logic [2:0] win_shift(input logic [2:0] code);
    return (code > 3'd5) ? 3'd5 : code;
  endfunction

  // status bits raised by one cycle's events
  function automatic logic [ST_W-1:0] event_bits(input wdg_evt_t e, input logic aux);
    logic [ST_W-1:0] s;
    s = '0;
    s[ST_AUX] = aux;
    if (e.expire) begin
      s[ST_EXP]  = 1'b1;
      s[ST_LATE] = 1'b1;
    end
    if (e.early) s[ST_EARLY] = 1'b1;
    if (e.badkey) s[ST_BAD] = 1'b1;
    s[ST_ANY] = e.expire | e.early | e.badkey;
    return s;
  endfunction

endpackage

// File: rtl/wdg_countdown.sv
module wdg_countdown import wdg_pkg::*; #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] preload_i,
  input  logic [2:0]       win_code_i,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             win_open_o,
  output logic             expire_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  function automatic logic [CNT_W-1:0] win_limit(input logic [CNT_W-1:0] pl,
                                                 input logic [2:0] code);
    return pl >> win_shift(code);
  endfunction

  assign win_open_o = (cnt_q <= win_limit(preload_i, win_code_i));
  assign expire_o   = run_q && tick_i && !reload_i && (cnt_q <= ONE);
  assign count_o    = cnt_q;
  assign running_o  = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= preload_i;
      run_q <= 1'b1;
    end else if (reload_i) begin
      cnt_q <= preload_i;
    end else if (expire_o) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !reload_i && !start_i) |=> $stable(cnt_q)); // R2
  AST_EXPIRE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (!run_q && cnt_q == '0)); // R8
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (cnt_q == $past(preload_i))); // R4

endmodule

// File: rtl/wdg_key_check.sv
module wdg_key_check import wdg_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             running_i,
  input  logic             win_open_i,
  input  logic             start_i,
  output logic             reload_o,
  output logic             early_o,
  output logic             badkey_o,
  output logic             armed_o,
  output logic             locked_o
);

  logic armed_q;
  logic lock_q;
  logic live, is_arm, is_fire, attempt;

  assign live    = key_wr_i && running_i && !lock_q;
  assign is_arm  = (key_i == KEY_ARM);
  assign is_fire = (key_i == KEY_FIRE);
  assign attempt = live && !is_arm;

  assign early_o  = attempt && !win_open_i;
  assign badkey_o = attempt && !(is_fire && armed_q);
  assign reload_o = attempt && is_fire && armed_q && win_open_i;
  assign armed_o  = armed_q;
  assign locked_o = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      lock_q  <= 1'b0;
    end else if (start_i) begin
      armed_q <= 1'b0;
      lock_q  <= 1'b0;
    end else if (live) begin
      armed_q <= is_arm;
      lock_q  <= early_o || badkey_o;
    end
  end

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !start_i) |=> lock_q); // R9
  AST_REARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (live && is_arm) |-> (!early_o && !badkey_o && !reload_o)); // R7

endmodule

// File: rtl/wdg_status.sv
module wdg_status import wdg_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            aux_i,
  input  wdg_evt_t        evt_i,
  input  logic            clr_i,
  input  logic [ST_W-1:0] clr_mask_i,
  input  logic            act_sel_i,
  input  logic            pulse_mode_i,
  output logic [ST_W-1:0] status_o,
  output logic            rst_req_o,
  output logic            nmi_o
);

  logic [ST_W-1:0] stat_q;
  logic [ST_W-1:0] set_bits, clr_bits;
  logic            pls_q;
  logic            act;

  assign set_bits = event_bits(evt_i, aux_i);
  assign clr_bits = clr_i ? clr_mask_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      pls_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_bits) | set_bits;
      pls_q  <= evt_i.expire | evt_i.early | evt_i.badkey;
    end
  end

  assign act       = pulse_mode_i ? pls_q : stat_q[ST_ANY];
  assign rst_req_o = act && !act_sel_i;
  assign nmi_o     = act && act_sel_i;
  assign status_o  = stat_q;

  for (genvar b = 0; b < ST_W; b++) begin : g_sticky
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[b] && !(clr_i && clr_mask_i[b])) |=> stat_q[b]); // R10
  end

  AST_SUMMARY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i.expire || evt_i.early || evt_i.badkey) |=> stat_q[ST_ANY]); // R5
  AST_AUX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    aux_i |=> stat_q[ST_AUX]); // R13
  AST_ACT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req_o && nmi_o)); // R12

endmodule

// File: rtl/windowed_watchdog.sv
module windowed_watchdog import wdg_pkg::*; #(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              aux_evt_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rst_req_o,
  output logic              nmi_o
);

  logic [CNT_W-1:0] preload_q;
  logic [2:0]       win_q;
  logic             sel_q, pm_q;

  logic [CNT_W-1:0] count;
  logic             running, win_open, expire;
  logic             start, key_wr, clr;
  logic             reload, early, badkey, armed, locked;
  logic [ST_W-1:0]  status;
  wdg_evt_t         evt;
  logic             unused_hi;

  assign unused_hi = ^wr_data_i[DATA_W-1:CNT_W];

  assign start  = wr_en_i && (wr_addr_i == A_CTRL) && wr_data_i[0] && !running;
  assign key_wr = wr_en_i && (wr_addr_i == A_KEY);
  assign clr    = wr_en_i && (wr_addr_i == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preload_q <= '0;
      win_q     <= '0;
      sel_q     <= 1'b0;
      pm_q      <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_CTRL: begin
          sel_q <= wr_data_i[1];
          pm_q  <= wr_data_i[2];
        end
        A_LOAD:  preload_q <= wr_data_i[CNT_W-1:0];
        A_WIN:   win_q     <= wr_data_i[2:0];
        default: ;
      endcase
    end
  end

  wdg_countdown #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .start_i    (start),
    .reload_i   (reload),
    .preload_i  (preload_q),
    .win_code_i (win_q),
    .count_o    (count),
    .running_o  (running),
    .win_open_o (win_open),
    .expire_o   (expire)
  );

  wdg_key_check u_key (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_wr_i   (key_wr),
    .key_i      (wr_data_i[KEY_W-1:0]),
    .running_i  (running),
    .win_open_i (win_open),
    .start_i    (start),
    .reload_o   (reload),
    .early_o    (early),
    .badkey_o   (badkey),
    .armed_o    (armed),
    .locked_o   (locked)
  );

  assign evt.expire = expire;
  assign evt.early  = early;
  assign evt.badkey = badkey;

  wdg_status u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .aux_i        (aux_evt_i),
    .evt_i        (evt),
    .clr_i        (clr),
    .clr_mask_i   (wr_data_i[ST_W-1:0]),
    .act_sel_i    (sel_q),
    .pulse_mode_i (pm_q),
    .status_o     (status),
    .rst_req_o    (rst_req_o),
    .nmi_o        (nmi_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_CTRL:  rd_data_o = DATA_W'({pm_q, sel_q, running});
      A_LOAD:  rd_data_o = DATA_W'(preload_q);
      A_WIN:   rd_data_o = DATA_W'(win_q);
      A_KEY:   rd_data_o = DATA_W'({locked, armed});
      A_STAT:  rd_data_o = DATA_W'(status);
      A_CNT:   rd_data_o = DATA_W'(count);
      default: rd_data_o = '0;
    endcase
  end

  AST_RELOAD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    reload |-> win_open); // R4
  AST_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !expire) |=> running); // R11
  AST_IDLE_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable({locked, armed})); // R14

endmodule

// File: tb/tb_windowed_watchdog.sv
`timescale 1ns/100ps
module tb_windowed_watchdog;
  localparam int CW = 24;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0, tick = 0, aux = 0, wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [DW-1:0] wr_data = 0;
  wire  [DW-1:0] rd_data;
  wire  rst_req, nmi;

  always #2.5 clk = ~clk;

  windowed_watchdog #(.CNT_W(CW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .aux_evt_i(aux),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .rst_req_o(rst_req), .nmi_o(nmi));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt = 0, m_pre = 0, m_win = 0, m_stat = 0;
  bit m_run = 0, m_lock = 0, m_arm = 0, m_sel = 0, m_pm = 0, m_pls = 0;
  int lim, k, clrm, setb;
  bit open, st, rl, ea, bd, ex;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_win = 0; m_stat = 0;
      m_run = 0; m_lock = 0; m_arm = 0; m_sel = 0; m_pm = 0; m_pls = 0;
    end else begin
      lim  = m_pre / (1 << ((m_win > 5) ? 5 : m_win));
      open = (m_cnt <= lim);
      st = 0; rl = 0; ea = 0; bd = 0; ex = 0; clrm = 0;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin
            if (wr_data[0] && !m_run) st = 1;
            m_sel = wr_data[1]; m_pm = wr_data[2];
          end
          3'd1: m_pre = int'(wr_data[CW-1:0]);
          3'd2: m_win = int'(wr_data[2:0]);
          3'd3: if (m_run && !m_lock) begin
            k = int'(wr_data[15:0]);
            if (k == 'hE51A) m_arm = 1;
            else begin
              if (!open) ea = 1;
              if (k == 'hA35C && m_arm) begin if (open) rl = 1; end
              else bd = 1;
              m_arm = 0;
              if (ea || bd) m_lock = 1;
            end
          end
          3'd4: clrm = int'(wr_data[5:0]);
          default: ;
        endcase
      end
      if (st) begin m_cnt = m_pre; m_run = 1; m_lock = 0; m_arm = 0; end
      else if (rl) m_cnt = m_pre;
      else if (tick && m_run) begin
        if (m_cnt <= 1) begin m_cnt = 0; m_run = 0; ex = 1; end
        else m_cnt--;
      end
      setb = (aux ? 'h01 : 0) | (ex ? 'h32 : 0) | (ea ? 'h28 : 0) | (bd ? 'h24 : 0);
      m_stat = (m_stat & ~clrm & 'h3F) | setb;
      m_pls = ex | ea | bd;
    end
  end

  // per-cycle observation and comparison
  int o_ctrl, o_key, o_stat, o_cnt;
  bit o_rst, o_nmi, e_act;

  always @(negedge clk) begin
    #0.2 rd_addr = 3'd0;
    #0.1 o_ctrl = int'(rd_data); rd_addr = 3'd3;
    #0.1 o_key = int'(rd_data);  rd_addr = 3'd4;
    #0.1 o_stat = int'(rd_data); rd_addr = 3'd5;
    #0.1 o_cnt = int'(rd_data);
    o_rst = rst_req; o_nmi = nmi;
    if (rst_n && !done) begin
      e_act = m_pm ? m_pls : m_stat[5];
      check("R2 model count", o_cnt, m_cnt);
      check("R2 model ctrl", o_ctrl, {m_pm, m_sel, m_run});
      check("R9 model key state", o_key, {m_lock, m_arm});
      check("R10 model status", o_stat, m_stat);
      check("R12 model reset request", o_rst, e_act && !m_sel);
      check("R12 model interrupt", o_nmi, e_act && m_sel);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #1.5;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #0.1;
    wr_en = 0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); #1.5; tick = 1;
      @(posedge clk); #0.1; tick = 0;
    end
  endtask

  task automatic look();
    @(negedge clk); #1.0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.1 rst_n = 1;
    look();
    check("R1 reset status", o_stat, 0);
    check("R1 reset count", o_cnt, 0);
    check("R1 reset ctrl", o_ctrl, 0);
    check("R1 reset actions", {o_rst, o_nmi}, 0);

    wr(3'd3, 32'hE51A); wr(3'd3, 32'hA35C); look();
    check("R14 idle keys status", o_stat, 0);
    check("R14 idle keys state", o_key, 0);

    wr(3'd1, 40); wr(3'd2, 1); wr(3'd0, 32'h1); look();
    check("R2 start count", o_cnt, 40);
    check("R2 start running", o_ctrl & 1, 1);
    ticks(5); look();
    check("R2 five ticks", o_cnt, 35);
    repeat (6) @(posedge clk); look();
    check("R2 no tick hold", o_cnt, 35);

    wr(3'd0, 32'h0); look();
    check("R11 stop ignored", o_ctrl & 1, 1);
    wr(3'd0, 32'h1); look();
    check("R11 restart ignored", o_cnt, 35);

    ticks(15);
    wr(3'd3, 32'hE51A); wr(3'd3, 32'hE51A); look();
    check("R7 rearm quiet", o_stat, 0);
    wr(3'd3, 32'hA35C); look();
    check("R4 service reload", o_cnt, 40);
    check("R4 service status", o_stat, 0);

    ticks(19);
    wr(3'd3, 32'hE51A); wr(3'd3, 32'hA35C); look();
    check("R5 early service", o_stat, 'h28);
    check("R12 level reset request", o_rst, 1);
    ticks(1);
    wr(3'd3, 32'hE51A); wr(3'd3, 32'hA35C); look();
    check("R9 locked keys count", o_cnt, 20);
    check("R9 locked keys status", o_stat, 'h28);
    ticks(20); look();
    check("R8 expire after early", o_stat, 'h3A);
    check("R8 halted", o_ctrl & 1, 0);
    ticks(3); look();
    check("R8 stays at zero", o_cnt, 0);

    wr(3'd4, 32'h08); look();
    check("R10 partial clear", o_stat, 'h32);
    wr(3'd4, 32'h3F); look();
    check("R10 full clear", o_stat, 0);
    check("R12 level drops", o_rst, 0);

    wr(3'd0, 32'h3); ticks(40); look();
    check("R8 plain expiry", o_stat, 'h32);
    check("R12 interrupt routed", {o_rst, o_nmi}, 1);
    wr(3'd4, 32'h3F);

    wr(3'd0, 32'h7); wr(3'd3, 32'hE53C);
    look();
    check("R6 bad first key early", o_stat, 'h2C);
    check("R12 pulse high", o_nmi, 1);
    look();
    check("R12 pulse one cycle", o_nmi, 0);
    ticks(40); look();
    check("R8 expiry after bad key", o_stat, 'h3E);
    wr(3'd4, 32'h3F);

    wr(3'd2, 0); wr(3'd0, 32'h1); wr(3'd3, 32'hA35C); look();
    check("R6 unarmed fire in window", o_stat, 'h24);
    check("R3 code0 full window open", o_stat & 'h08, 0);
    ticks(40); wr(3'd4, 32'h3F);

    wr(3'd1, 64); wr(3'd2, 7); wr(3'd0, 32'h1);
    ticks(61);
    wr(3'd3, 32'hE51A); wr(3'd3, 32'hA35C); look();
    check("R3 code7 closed at 3", o_stat, 'h28);
    ticks(3); wr(3'd4, 32'h3F);
    wr(3'd0, 32'h1); ticks(62);
    wr(3'd3, 32'hE51A); wr(3'd3, 32'hA35C); look();
    check("R3 code7 open at 2", o_cnt, 64);
    check("R3 code7 no fault", o_stat, 0);

    @(negedge clk); #1.5 aux = 1;
    @(posedge clk); #0.1 aux = 0;
    look();
    check("R13 aux sets bit0", o_stat, 'h01);
    check("R13 aux no action", {o_rst, o_nmi}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule